// File: doc/BRIEF.md
# Class-D Output Stage Protection Supervisor

This block watches the health of a four-half-bridge class-D output stage and decides when the stage may drive its load. It receives digitized status: one overcurrent flag per half-bridge, an unsigned junction-temperature code in degrees Celsius, "supply good" flags for the analog rail and for two power-stage rails, and a power-on-reset level. From these it produces one high-impedance command, copied to every half-bridge, and an active-low fault line.

Overcurrent on any bridge stops the whole stage. The overcurrent state is held in a latch until the flags have been clean for a programmable number of cycles. A thermal trip applies a fixed hysteresis band before the stage may drive again. A low supply on any of the three rails, or an active power-on reset, disables the stage as soon as the synchronized flag shows it. A small cause register records which fault classes brought the stage down. Software clears it with write-one pulses.

Top module: `amp_fault_guard`

## Requirements
- R1: A high overcurrent flag on any one bridge sets every bit of `bridgeHiZ` and drives `faultN` low. The change shows at the outputs on the second rising clock edge after the flag is applied.
- R2: The overcurrent shutdown holds while any flag is high. It is released on the `OC_RELEASE_CYC`-th edge (default 8) after the synchronized flags are seen all low. With the default value, the outputs recover on the 10th edge after the flags fall.
- R3: A temperature code strictly above 150 trips thermal shutdown. The stage stays shut while the code is above 120 and releases once the code is 120 or less. A code of exactly 150 does not trip.
- R4: A low good flag on the analog rail (`avddGoodIn`) or on either power-stage rail (`pvddGoodIn[0]` or `pvddGoodIn[1]`) forces high-impedance and `faultN` low on the second edge after it is applied. Each rail alone is enough.
- R5: While `porIn` is high the stage is held in high-impedance. The power-on reset also clears the overcurrent latch, so after it falls the stage recovers without waiting out the release count.
- R6: `faultN` is always the inverse of the shared high-impedance command. It rises in the same cycle that the last active fault class clears.
- R7: `causeOut` bit 0 is overcurrent, bit 1 is thermal and bit 2 is undervoltage or power-on reset. When the stage enters shutdown, the register is loaded with the classes active at that moment. Classes that become active later in the same shutdown are added to it.
- R8: A 1 on `causeClrIn[n]` clears `causeOut[n]` one edge later. If the class is being recorded in the same cycle, the recording wins. Bits written 0 are unchanged.
- R9: While `rstN` is low, `bridgeHiZ` is all ones, `faultN` is 0 and `causeOut` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Supervisor clock |
| rstN | input | 1 | Asynchronous active-low reset |
| porIn | input | 1 | Power-on-reset level, high while supplies are settling |
| ocFlagIn | input | NUM_BRIDGES | Overcurrent flag per half-bridge, asynchronous |
| tempCodeIn | input | TEMP_W | Junction temperature, unsigned degrees Celsius |
| avddGoodIn | input | 1 | Analog rail above its threshold |
| pvddGoodIn | input | 2 | Power-stage rails above their thresholds |
| causeClrIn | input | 3 | Write-one clear pulses for the cause bits |
| bridgeHiZ | output | NUM_BRIDGES | High-impedance command, identical on every bridge |
| faultN | output | 1 | Active-low fault indication |
| causeOut | output | 3 | Recorded shutdown causes {uv, thermal, overcurrent} |

## Verification
The assertions assume that the status inputs are level signals that stay put for several clock cycles. They also assume that the multi-bit temperature code does not change while it is being synchronized, so the comparators never see a mix of old and new bits. `causeClrIn` is taken as a synchronous pulse that needs no synchronizer. The stimulus changes every input only at falling clock edges and holds each pattern for many cycles. Rail changes that must not open a gap in the undervoltage condition are applied in a single step.

// File: rtl/amp_guard_pkg.sv
`timescale 1ns/1ps
package amp_guard_pkg;

  // Fault classes, packed so that bit 0 = overcurrent, bit 1 = thermal, bit 2 = undervoltage
  typedef struct packed {
    logic uv;
    logic therm;
    logic oc;
  } faultClass_t;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic cntClr;     // restart the overcurrent release counter
    logic cntRun;     // advance the release counter
    logic causeLoad;  // shutdown entry: replace recorded causes
    logic causeMerge; // shutdown ongoing: add newly active causes
  } guardStrobe_t;

endpackage

// File: rtl/amp_guard_sync.sv
`timescale 1ns/1ps
module amp_guard_sync #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  logic [W-1:0] stageOne;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageOne <= RST_VAL;
      syncOut  <= RST_VAL;
    end else begin
      stageOne <= asyncIn;
      syncOut  <= stageOne;
    end
  end

endmodule

// File: rtl/amp_guard_datapath.sv
`timescale 1ns/1ps
module amp_guard_datapath
  import amp_guard_pkg::*;
#(
  parameter int NUM_BRIDGES    = 4,
  parameter int TEMP_W         = 8,
  parameter int TEMP_TRIP      = 150,
  parameter int TEMP_HYST      = 30,
  parameter int OC_RELEASE_CYC = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   porIn,
  input  logic [NUM_BRIDGES-1:0] ocFlagIn,
  input  logic [TEMP_W-1:0]      tempCodeIn,
  input  logic                   avddGoodIn,
  input  logic [1:0]             pvddGoodIn,
  input  logic [2:0]             causeClrIn,
  input  guardStrobe_t           strobe,
  input  logic                   activeOc,
  input  logic                   activeTherm,
  output logic                   porSync,
  output logic                   anyOc,
  output logic                   tempHigh,
  output logic                   tempCool,
  output logic                   uvNow,
  output logic                   cntDone,
  output logic [2:0]             causeOut
);

  localparam int               CNT_W     = (OC_RELEASE_CYC > 2) ? $clog2(OC_RELEASE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(OC_RELEASE_CYC - 1);
  localparam logic [TEMP_W-1:0] TRIP_CODE = TEMP_W'(TEMP_TRIP);
  localparam logic [TEMP_W-1:0] REL_CODE  = TEMP_W'(TEMP_TRIP - TEMP_HYST);
  localparam int               SUP_W     = 3;

  logic [NUM_BRIDGES-1:0] ocQ;
  logic [TEMP_W-1:0]      tempQ;
  logic [SUP_W-1:0]       supplyQ;
  logic                   porQ;

  // Synchronizers: reset values chosen so the stage starts disabled
  amp_guard_sync #(.W(NUM_BRIDGES), .RST_VAL('0)) i_ocSync (
    .clk(clk), .rstN(rstN), .asyncIn(ocFlagIn), .syncOut(ocQ)
  );
  amp_guard_sync #(.W(TEMP_W), .RST_VAL('0)) i_tempSync (
    .clk(clk), .rstN(rstN), .asyncIn(tempCodeIn), .syncOut(tempQ)
  );
  amp_guard_sync #(.W(SUP_W), .RST_VAL('0)) i_supplySync (
    .clk(clk), .rstN(rstN), .asyncIn({pvddGoodIn, avddGoodIn}), .syncOut(supplyQ)
  );
  amp_guard_sync #(.W(1), .RST_VAL(1'b1)) i_porSync (
    .clk(clk), .rstN(rstN), .asyncIn(porIn), .syncOut(porQ)
  );

  assign porSync  = porQ;
  assign anyOc    = |ocQ;
  assign tempHigh = tempQ > TRIP_CODE;
  assign tempCool = tempQ <= REL_CODE;
  assign uvNow    = porQ | ~(&supplyQ);

  // Overcurrent release qualification counter
  logic [CNT_W-1:0] relCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      relCnt <= '0;
    else if (strobe.cntClr)
      relCnt <= '0;
    else if (strobe.cntRun && !cntDone)
      relCnt <= relCnt + 1'b1;
  end

  assign cntDone = (relCnt == CNT_LAST);

  // Cause register
  faultClass_t activeNow;
  logic [2:0]  activeBits;
  logic [2:0]  setMask;
  logic [2:0]  causeNext;
  logic [2:0]  causeReg;

  always_comb begin
    activeNow.uv    = uvNow;
    activeNow.therm = activeTherm;
    activeNow.oc    = activeOc;
    activeBits      = activeNow;
    setMask         = (strobe.causeLoad || strobe.causeMerge) ? activeBits : 3'b000;
    causeNext       = strobe.causeLoad ? activeBits : (causeReg | setMask);
    causeNext       = causeNext & ~(causeClrIn & ~setMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      causeReg <= '0;
    else
      causeReg <= causeNext;
  end

  assign causeOut = causeReg;

  // R8
  cause_clr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (causeClrIn[0] && !strobe.causeLoad && !strobe.causeMerge) |=> !causeOut[0])
    else $error("cause bit 0 survived an idle clear");

  // R7
  cause_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.causeLoad && uvNow) |=> causeOut[2])
    else $error("undervoltage not recorded at shutdown entry");

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntDone |=> (cntDone || relCnt == '0))
    else $error("release counter left its final value other than by restart");

endmodule

// File: rtl/amp_guard_ctrl.sv
`timescale 1ns/1ps
module amp_guard_ctrl
  import amp_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         porSync,
  input  logic         anyOc,
  input  logic         tempHigh,
  input  logic         tempCool,
  input  logic         uvNow,
  input  logic         cntDone,
  output guardStrobe_t strobe,
  output logic         activeOc,
  output logic         activeTherm,
  output logic         hiZ
);

  logic ocLatch;
  logic thermShut;
  logic hiZPrev;

  // Overcurrent latch: set by any flag, cleared by power-on reset or a qualified release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ocLatch <= 1'b0;
    else if (porSync)
      ocLatch <= 1'b0;
    else if (anyOc)
      ocLatch <= 1'b1;
    else if (cntDone)
      ocLatch <= 1'b0;
  end

  // Thermal shutdown with hysteresis
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      thermShut <= 1'b0;
    else if (tempHigh)
      thermShut <= 1'b1;
    else if (tempCool)
      thermShut <= 1'b0;
  end

  // Reset value 1: the stage is considered already shut down at reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      hiZPrev <= 1'b1;
    else
      hiZPrev <= hiZ;
  end

  assign activeOc    = ocLatch | anyOc;
  assign activeTherm = thermShut;
  assign hiZ         = activeOc | thermShut | uvNow;

  always_comb begin
    strobe.cntClr     = porSync | anyOc | ~ocLatch;
    strobe.cntRun     = ~strobe.cntClr;
    strobe.causeLoad  = hiZ & ~hiZPrev;
    strobe.causeMerge = hiZ & hiZPrev;
  end

  // R1
  oc_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (anyOc && !porSync) |=> ocLatch)
    else $error("overcurrent did not latch");

  // R2
  oc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ocLatch && !cntDone && !porSync) |=> ocLatch)
    else $error("overcurrent latch released before qualification");

  // R5
  por_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    porSync |=> !ocLatch)
    else $error("power-on reset did not clear the overcurrent latch");

  // R3
  therm_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    tempHigh |=> thermShut)
    else $error("thermal trip missed");

  // R3
  therm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (thermShut && !tempCool) |=> thermShut)
    else $error("thermal shutdown released inside the hysteresis band");

  // R6
  release_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hiZ) |-> (!ocLatch && !thermShut && !uvNow && !anyOc))
    else $error("stage released with a fault class still active");

endmodule

// File: rtl/amp_fault_guard.sv
`timescale 1ns/1ps
module amp_fault_guard
  import amp_guard_pkg::*;
#(
  parameter int NUM_BRIDGES    = 4,
  parameter int TEMP_W         = 8,
  parameter int TEMP_TRIP      = 150,
  parameter int TEMP_HYST      = 30,
  parameter int OC_RELEASE_CYC = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   porIn,
  input  logic [NUM_BRIDGES-1:0] ocFlagIn,
  input  logic [TEMP_W-1:0]      tempCodeIn,
  input  logic                   avddGoodIn,
  input  logic [1:0]             pvddGoodIn,
  input  logic [2:0]             causeClrIn,
  output logic [NUM_BRIDGES-1:0] bridgeHiZ,
  output logic                   faultN,
  output logic [2:0]             causeOut
);

  guardStrobe_t strobe;
  logic porSync, anyOc, tempHigh, tempCool, uvNow, cntDone;
  logic activeOc, activeTherm, hiZ;

  amp_guard_datapath #(
    .NUM_BRIDGES(NUM_BRIDGES), .TEMP_W(TEMP_W), .TEMP_TRIP(TEMP_TRIP),
    .TEMP_HYST(TEMP_HYST), .OC_RELEASE_CYC(OC_RELEASE_CYC)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .porIn(porIn), .ocFlagIn(ocFlagIn),
    .tempCodeIn(tempCodeIn), .avddGoodIn(avddGoodIn), .pvddGoodIn(pvddGoodIn),
    .causeClrIn(causeClrIn), .strobe(strobe), .activeOc(activeOc),
    .activeTherm(activeTherm), .porSync(porSync), .anyOc(anyOc),
    .tempHigh(tempHigh), .tempCool(tempCool), .uvNow(uvNow),
    .cntDone(cntDone), .causeOut(causeOut)
  );

  amp_guard_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .porSync(porSync), .anyOc(anyOc),
    .tempHigh(tempHigh), .tempCool(tempCool), .uvNow(uvNow),
    .cntDone(cntDone), .strobe(strobe), .activeOc(activeOc),
    .activeTherm(activeTherm), .hiZ(hiZ)
  );

  // One shared command fans out to every half-bridge
  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
    assign bridgeHiZ[b] = hiZ;
  end

  assign faultN = ~hiZ;

  // R4
  uv_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    uvNow |-> (&bridgeHiZ && !faultN))
    else $error("undervoltage without full shutdown");

endmodule

// File: tb/test_amp_fault_guard.sv
`timescale 1ns/1ps
module test_amp_fault_guard;

  localparam int NB = 4;
  localparam int TW = 8;
  localparam int NV = 20;
  localparam int HOLD = 14;

  logic          clk = 1'b0;
  logic          rstN;
  logic          porIn;
  logic [NB-1:0] ocFlagIn;
  logic [TW-1:0] tempCodeIn;
  logic          avddGoodIn;
  logic [1:0]    pvddGoodIn;
  logic [2:0]    causeClrIn;
  logic [NB-1:0] bridgeHiZ;
  logic          faultN;
  logic [2:0]    causeOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  amp_fault_guard #(.NUM_BRIDGES(NB), .TEMP_W(TW)) i_amp_fault_guard (
    .clk(clk), .rstN(rstN), .porIn(porIn), .ocFlagIn(ocFlagIn),
    .tempCodeIn(tempCodeIn), .avddGoodIn(avddGoodIn), .pvddGoodIn(pvddGoodIn),
    .causeClrIn(causeClrIn), .bridgeHiZ(bridgeHiZ), .faultN(faultN),
    .causeOut(causeOut)
  );

  typedef struct packed {
    logic       por;
    logic [3:0] oc;
    logic [7:0] temp;
    logic       avdd;
    logic [1:0] pvdd;
    logic [2:0] clr;
    logic       expHiZ;
    logic [2:0] expCause;
    logic [7:0] req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'h0, 8'd25,  1'b1, 2'b11, 3'b000, 1'b0, 3'b100, 8'd9}, // R9 reset-time uv recorded, R5 por release
    '{1'b0, 4'h0, 8'd25,  1'b1, 2'b11, 3'b111, 1'b0, 3'b000, 8'd8}, // R8 clear all
    '{1'b0, 4'h1, 8'd25,  1'b1, 2'b11, 3'b000, 1'b1, 3'b001, 8'd1}, // R1 bridge 0 trips all
    '{1'b0, 4'h0, 8'd25,  1'b1, 2'b11, 3'b000, 1'b0, 3'b001, 8'd2}, // R2 released
    '{1'b0, 4'h4, 8'd25,  1'b1, 2'b11, 3'b001, 1'b1, 3'b001, 8'd8}, // R8 set beats clear
    '{1'b0, 4'h0, 8'd25,  1'b1, 2'b11, 3'b111, 1'b0, 3'b000, 8'd2}, // R2 release, clear
    '{1'b0, 4'h0, 8'd151, 1'b1, 2'b11, 3'b000, 1'b1, 3'b010, 8'd3}, // R3 trip
    '{1'b0, 4'h0, 8'd121, 1'b1, 2'b11, 3'b000, 1'b1, 3'b010, 8'd3}, // R3 inside band
    '{1'b0, 4'h0, 8'd120, 1'b1, 2'b11, 3'b000, 1'b0, 3'b010, 8'd3}, // R3 release at 120
    '{1'b0, 4'h0, 8'd150, 1'b1, 2'b11, 3'b111, 1'b0, 3'b000, 8'd3}, // R3 150 does not trip
    '{1'b0, 4'h0, 8'd25,  1'b0, 2'b11, 3'b000, 1'b1, 3'b100, 8'd4}, // R4 analog rail low
    '{1'b0, 4'h0, 8'd25,  1'b1, 2'b10, 3'b000, 1'b1, 3'b100, 8'd4}, // R4 power rail 0 low
    '{1'b0, 4'h0, 8'd25,  1'b1, 2'b01, 3'b000, 1'b1, 3'b100, 8'd4}, // R4 power rail 1 low
    '{1'b0, 4'h0, 8'd25,  1'b1, 2'b11, 3'b111, 1'b0, 3'b000, 8'd6}, // R6 all clear
    '{1'b0, 4'h0, 8'd200, 1'b0, 2'b11, 3'b000, 1'b1, 3'b110, 8'd7}, // R7 merge thermal into uv
    '{1'b0, 4'h0, 8'd25,  1'b1, 2'b11, 3'b000, 1'b0, 3'b110, 8'd7}, // R7 causes kept
    '{1'b0, 4'h0, 8'd25,  1'b1, 2'b11, 3'b010, 1'b0, 3'b100, 8'd8}, // R8 single bit clear
    '{1'b1, 4'h8, 8'd25,  1'b1, 2'b11, 3'b000, 1'b1, 3'b101, 8'd5}, // R5 por with overcurrent
    '{1'b0, 4'h8, 8'd25,  1'b1, 2'b11, 3'b000, 1'b1, 3'b101, 8'd5}, // R5 oc still present
    '{1'b0, 4'h0, 8'd25,  1'b1, 2'b11, 3'b111, 1'b0, 3'b000, 8'd2}  // R2 final release
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkStage(input logic expHiZ, input string tag);
    check(bridgeHiZ == {NB{expHiZ}}, tag, int'(bridgeHiZ), int'({NB{expHiZ}}));
    check(faultN == ~expHiZ, {tag, " faultN"}, int'(faultN), int'(~expHiZ));
  endtask

  initial begin
    rstN = 1'b0; porIn = 1'b1; ocFlagIn = '0; tempCodeIn = 8'd25;
    avddGoodIn = 1'b1; pvddGoodIn = 2'b11; causeClrIn = 3'b000;
    repeat (3) @(negedge clk);
    // R9 reset state
    checkStage(1'b1, "R9");
    check(causeOut == 3'b000, "R9 cause", int'(causeOut), 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      porIn = VECS[i].por; ocFlagIn = VECS[i].oc; tempCodeIn = VECS[i].temp;
      avddGoodIn = VECS[i].avdd; pvddGoodIn = VECS[i].pvdd; causeClrIn = VECS[i].clr;
      waitEdges(HOLD);
      checkStage(VECS[i].expHiZ, $sformatf("R%0d vec%0d", VECS[i].req, i));
      check(causeOut == VECS[i].expCause, $sformatf("R%0d vec%0d cause", VECS[i].req, i),
            int'(causeOut), int'(VECS[i].expCause));
    end
    causeClrIn = 3'b000;

    // R4 latency: visible on the second edge
    avddGoodIn = 1'b0;
    waitEdges(1);
    checkStage(1'b0, "R4 latency edge1");
    waitEdges(1);
    checkStage(1'b1, "R4 latency edge2");
    avddGoodIn = 1'b1;
    waitEdges(4);
    checkStage(1'b0, "R6 recovered");

    // R1 latency, single bridge
    ocFlagIn = 4'b0010;
    waitEdges(1);
    checkStage(1'b0, "R1 latency edge1");
    waitEdges(1);
    checkStage(1'b1, "R1 latency edge2");
    waitEdges(3);

    // R2 exact release edge
    ocFlagIn = '0;
    waitEdges(9);
    checkStage(1'b1, "R2 edge9 still held");
    waitEdges(1);
    checkStage(1'b0, "R2 edge10 released");

    // R5 power-on reset clears the latch
    ocFlagIn = 4'b0001;
    waitEdges(5);
    ocFlagIn = '0; porIn = 1'b1;
    waitEdges(3);
    checkStage(1'b1, "R5 por holds");
    porIn = 1'b0;
    waitEdges(2);
    checkStage(1'b0, "R5 latch cleared");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule